// File: doc/BRIEF.md
# UART Character Buffer Pair with Selectable Interrupt Thresholds

This block holds the receive and transmit character queues of one UART channel. The serial side pushes received characters into the receive queue, each with a three-bit error tag. It pops characters that the host has written from the transmit queue. The host side pops received characters and pushes characters to be sent. Each direction drives a level-sensitive interrupt request that compares the queue's fill state with a threshold.

Each threshold has two possible sources. A coarse two-bit selector picks one of four fixed levels. A fine four-bit field gives a level in steps of four characters. Whenever the fine field is nonzero, it takes precedence. When the queues are disabled, which is their state after reset, each queue holds one character and both thresholds become one. Separate flush pulses empty either queue without touching the threshold settings.

Top module: `uart_fifo_pair`

## Requirements
- R1: When enabled, each queue holds at most 64 entries and `rx_count`/`tx_count` never exceed 64. A host write into a full transmit queue is discarded and the stored contents stay unchanged.
- R2: A receive entry is 8 data bits plus a 3-bit error tag. `host_rdata`/`host_rerr` always show the oldest entry, and entries leave in arrival order.
- R3: After reset the queues are disabled. Capacity is then 1 and both thresholds are 1: `rx_irq` is high when one character is held, and `tx_irq` is high only while the transmit queue is empty. Reset state: both counts 0, `rx_irq` 0, `tx_irq` 1, `rx_overrun` 0.
- R4: With a zero fine field, the coarse receive selector values 0, 1, 2 and 3 give receive thresholds of 8, 16, 56 and 60 characters.
- R5: With a zero fine field, the coarse transmit selector values 0, 1, 2 and 3 give transmit thresholds of 8, 16, 32 and 56 free spaces.
- R6: A nonzero fine field F for a direction sets that direction's threshold to 4*F and overrides its coarse selector. Receive and transmit settings act independently.
- R7: `rx_irq` is high while `rx_count` is at or above the receive threshold. `tx_irq` is high while the free transmit space (capacity minus `tx_count`) is at or above the transmit threshold.
- R8: A pulse on `rx_flush` or `tx_flush` empties only that queue by the next cycle. It leaves the other queue and all threshold settings unchanged, and it wins over a push in the same cycle.
- R9: A push into a full receive queue is dropped and sets `rx_overrun`. The flag stays set until a receive flush or reset.
- R10: A configuration write that changes the enable bit empties both queues.
- R11: A pop of an empty queue has no effect. A push and a pop in the same cycle on a full queue are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Loads all configuration fields below |
| cfg_fifo_en | input | 1 | Queue enable (0 = single-character mode) |
| cfg_rx_sel | input | 2 | Coarse receive threshold selector |
| cfg_tx_sel | input | 2 | Coarse transmit threshold selector |
| cfg_rx_fine | input | 4 | Fine receive threshold, units of 4 |
| cfg_tx_fine | input | 4 | Fine transmit threshold, units of 4 |
| rx_flush | input | 1 | Pulse: empty the receive queue |
| tx_flush | input | 1 | Pulse: empty the transmit queue |
| host_wr | input | 1 | Host pushes a transmit character |
| host_wdata | input | 8 | Transmit character |
| host_rd | input | 1 | Host pops the oldest received entry |
| host_rdata | output | 8 | Oldest received character |
| host_rerr | output | 3 | Error tag of the oldest received character |
| ser_rx_push | input | 1 | Serial side pushes a received character |
| ser_rx_data | input | 8 | Received character |
| ser_rx_err | input | 3 | Error tag of the received character |
| ser_tx_pop | input | 1 | Serial side pops the oldest transmit character |
| ser_tx_data | output | 8 | Oldest transmit character |
| rx_count | output | 7 | Receive fill level |
| tx_count | output | 7 | Transmit fill level |
| rx_irq | output | 1 | Receive threshold request |
| tx_irq | output | 1 | Transmit threshold request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
The threshold logic is driven with a table of settings: all four coarse codes per direction, fine values at the low end, the high end and in the middle, mixed combinations where only one direction uses its fine field, and disabled mode with a fine value present. Each setting is probed one character below and at the expected edge. This separates an off-by-one compare, a swapped coarse table, a fine field that fails to override, and a disabled mode that ignores the fallback. Directed sequences then fill the queues to the limit and check the overrun, the dropped transmit write, flush priority over a push, a simultaneous push and pop when full, and the flush caused by toggling the enable bit.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } fifo_dir_e;

    localparam int CHAR_W   = 8;
    localparam int ERR_W    = 3;
    localparam int SEL_W    = 2;
    localparam int FINE_W   = 4;
    localparam int FINE_MUL = 4;

    // coarse receive levels (characters held)
    localparam int RX_LVL0 = 8;
    localparam int RX_LVL1 = 16;
    localparam int RX_LVL2 = 56;
    localparam int RX_LVL3 = 60;
    // coarse transmit levels (free spaces)
    localparam int TX_LVL0 = 8;
    localparam int TX_LVL1 = 16;
    localparam int TX_LVL2 = 32;
    localparam int TX_LVL3 = 56;

endpackage

// File: rtl/ufp_queue.sv
module ufp_queue #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             single,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CNT_W-1:0] count,
    output logic             push_drop
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } q_state_t;

    q_state_t s_q, s_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cap;
    logic pop_ok, push_ok, wr_en;

    always_comb begin
        cap       = single ? CNT_W'(1) : CNT_W'(DEPTH);
        pop_ok    = pop && (s_q.cnt != '0);
        push_ok   = push && ((s_q.cnt < cap) || pop_ok);
        wr_en     = push_ok && !flush;
        push_drop = push && !push_ok && !flush;
        s_d       = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wptr = s_q.wptr + PTR_W'(1);
            if (pop_ok)  s_d.rptr = s_q.rptr + PTR_W'(1);
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[s_q.wptr] <= din;
    end

    assign dout  = mem[s_q.rptr];
    assign count = s_q.cnt;

endmodule

// File: rtl/ufp_threshold.sv
module ufp_threshold
    import uart_fifo_pkg::*;
#(
    parameter fifo_dir_e DIR   = DIR_RX,
    parameter int        CNT_W = 7
) (
    input  logic              fifo_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [FINE_W-1:0] fine,
    output logic [CNT_W-1:0]  level
);

    logic [CNT_W-1:0] coarse;

    generate
        if (DIR == DIR_RX) begin : g_rx_table
            always_comb begin
                case (sel)
                    2'd0:    coarse = CNT_W'(RX_LVL0);
                    2'd1:    coarse = CNT_W'(RX_LVL1);
                    2'd2:    coarse = CNT_W'(RX_LVL2);
                    default: coarse = CNT_W'(RX_LVL3);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                case (sel)
                    2'd0:    coarse = CNT_W'(TX_LVL0);
                    2'd1:    coarse = CNT_W'(TX_LVL1);
                    2'd2:    coarse = CNT_W'(TX_LVL2);
                    default: coarse = CNT_W'(TX_LVL3);
                endcase
            end
        end
    endgenerate

    always_comb begin
        if (!fifo_en)          level = CNT_W'(1);
        else if (fine != '0)   level = CNT_W'(fine) * CNT_W'(FINE_MUL);
        else                   level = coarse;
    end

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RXE_W = CHAR_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_fifo_en,
    input  logic [SEL_W-1:0]  cfg_rx_sel,
    input  logic [SEL_W-1:0]  cfg_tx_sel,
    input  logic [FINE_W-1:0] cfg_rx_fine,
    input  logic [FINE_W-1:0] cfg_tx_fine,
    input  logic              rx_flush,
    input  logic              tx_flush,
    input  logic              host_wr,
    input  logic [CHAR_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [CHAR_W-1:0] host_rdata,
    output logic [ERR_W-1:0]  host_rerr,
    input  logic              ser_rx_push,
    input  logic [CHAR_W-1:0] ser_rx_data,
    input  logic [ERR_W-1:0]  ser_rx_err,
    input  logic              ser_tx_pop,
    output logic [CHAR_W-1:0] ser_tx_data,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_overrun
);

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  rx_sel;
        logic [SEL_W-1:0]  tx_sel;
        logic [FINE_W-1:0] rx_fine;
        logic [FINE_W-1:0] tx_fine;
        logic              ovr;
    } ctl_t;

    ctl_t c_q, c_d;
    logic en_toggle, rx_clr, tx_clr, rx_drop, tx_drop_unused;
    logic [RXE_W-1:0] rx_head;
    logic [CNT_W-1:0] rx_thr, tx_thr, cap, tx_free;

    always_comb begin
        en_toggle = cfg_we && (cfg_fifo_en != c_q.en);
        rx_clr    = rx_flush || en_toggle;
        tx_clr    = tx_flush || en_toggle;
        c_d       = c_q;
        if (cfg_we) begin
            c_d.en      = cfg_fifo_en;
            c_d.rx_sel  = cfg_rx_sel;
            c_d.tx_sel  = cfg_tx_sel;
            c_d.rx_fine = cfg_rx_fine;
            c_d.tx_fine = cfg_tx_fine;
        end
        if (rx_clr)       c_d.ovr = 1'b0;
        else if (rx_drop) c_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    ufp_queue #(.DEPTH(DEPTH), .WIDTH(RXE_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rx_clr), .single(!c_q.en),
        .push(ser_rx_push), .din({ser_rx_err, ser_rx_data}),
        .pop(host_rd), .dout(rx_head), .count(rx_count),
        .push_drop(rx_drop)
    );

    ufp_queue #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(tx_clr), .single(!c_q.en),
        .push(host_wr), .din(host_wdata),
        .pop(ser_tx_pop), .dout(ser_tx_data), .count(tx_count),
        .push_drop(tx_drop_unused)
    );

    ufp_threshold #(.DIR(DIR_RX), .CNT_W(CNT_W)) u_rx_thr (
        .fifo_en(c_q.en), .sel(c_q.rx_sel), .fine(c_q.rx_fine), .level(rx_thr)
    );

    ufp_threshold #(.DIR(DIR_TX), .CNT_W(CNT_W)) u_tx_thr (
        .fifo_en(c_q.en), .sel(c_q.tx_sel), .fine(c_q.tx_fine), .level(tx_thr)
    );

    always_comb begin
        cap     = c_q.en ? CNT_W'(DEPTH) : CNT_W'(1);
        tx_free = cap - tx_count;
    end

    assign host_rdata = rx_head[CHAR_W-1:0];
    assign host_rerr  = rx_head[RXE_W-1:CHAR_W];
    assign rx_irq     = (rx_count >= rx_thr);
    assign tx_irq     = (tx_free >= tx_thr);
    assign rx_overrun = c_q.ovr;

endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             cfg_we,
    input logic             rx_flush,
    input logic             ser_rx_push,
    input logic             host_rd,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_irq,
    input logic             rx_overrun
);

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CNT_W'(DEPTH)) && (tx_count <= CNT_W'(DEPTH)));

    assert_single_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_count <= CNT_W'(1)) && (tx_count <= CNT_W'(1)));

    assert_irq_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_count != '0));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_count == '0) && !rx_overrun);

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !rx_flush && !cfg_we) |=> rx_overrun);

    assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && rx_count == CNT_W'(DEPTH) && ser_rx_push && !host_rd && !rx_flush && !cfg_we)
        |=> rx_overrun && (rx_count == CNT_W'(DEPTH)));

    assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0 && host_rd && !ser_rx_push) |=> (rx_count == '0));

endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(c_q.en), .cfg_we(cfg_we),
    .rx_flush(rx_flush), .ser_rx_push(ser_rx_push), .host_rd(host_rd),
    .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq),
    .rx_overrun(rx_overrun)
);

// File: tb/uart_fifo_pair_bench.sv
`timescale 1ns/1ps
module uart_fifo_pair_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 0, cfg_fifo_en = 0;
    logic [1:0] cfg_rx_sel = 0, cfg_tx_sel = 0;
    logic [3:0] cfg_rx_fine = 0, cfg_tx_fine = 0;
    logic       rx_flush = 0, tx_flush = 0;
    logic       host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0;
    logic [7:0] host_rdata;
    logic [2:0] host_rerr;
    logic       ser_rx_push = 0, ser_tx_pop = 0;
    logic [7:0] ser_rx_data = 0;
    logic [2:0] ser_rx_err = 0;
    logic [7:0] ser_tx_data;
    logic [6:0] rx_count, tx_count;
    logic       rx_irq, tx_irq, rx_overrun;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_fifo_pair u_uart_fifo_pair (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .cfg_rx_sel(cfg_rx_sel), .cfg_tx_sel(cfg_tx_sel),
        .cfg_rx_fine(cfg_rx_fine), .cfg_tx_fine(cfg_tx_fine),
        .rx_flush(rx_flush), .tx_flush(tx_flush),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rerr(host_rerr),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_err(ser_rx_err),
        .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_overrun(rx_overrun)
    );

    typedef struct packed {
        logic       en;
        logic [1:0] rsel;
        logic [1:0] tsel;
        logic [3:0] rfine;
        logic [3:0] tfine;
        logic [6:0] rthr;
        logic [6:0] tthr;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 2'd0, 2'd0, 4'd0,  4'd0,  7'd8,  7'd8 },  // R4 R5
        '{1'b1, 2'd1, 2'd1, 4'd0,  4'd0,  7'd16, 7'd16},  // R4 R5
        '{1'b1, 2'd2, 2'd2, 4'd0,  4'd0,  7'd56, 7'd32},  // R4 R5
        '{1'b1, 2'd3, 2'd3, 4'd0,  4'd0,  7'd60, 7'd56},  // R4 R5
        '{1'b1, 2'd3, 2'd3, 4'd1,  4'd15, 7'd4,  7'd60},  // R6
        '{1'b1, 2'd0, 2'd2, 4'd7,  4'd0,  7'd28, 7'd32},  // R6
        '{1'b1, 2'd1, 2'd0, 4'd0,  4'd3,  7'd16, 7'd12},  // R6
        '{1'b1, 2'd2, 2'd1, 4'd15, 4'd2,  7'd60, 7'd8 },  // R6
        '{1'b0, 2'd3, 2'd3, 4'd5,  4'd5,  7'd1,  7'd1 }   // R3
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic flush_both();
        rx_flush = 1; tx_flush = 1; tick(); rx_flush = 0; tx_flush = 0;
    endtask

    task automatic write_cfg(logic en, logic [1:0] rs, logic [1:0] ts,
                             logic [3:0] rf, logic [3:0] tf);
        cfg_we = 1; cfg_fifo_en = en; cfg_rx_sel = rs; cfg_tx_sel = ts;
        cfg_rx_fine = rf; cfg_tx_fine = tf;
        tick();
        cfg_we = 0;
    endtask

    task automatic rx_push_n(int n, int base);
        for (int i = 0; i < n; i++) begin
            ser_rx_push = 1; ser_rx_data = 8'(base + i); ser_rx_err = 3'(i);
            tick();
        end
        ser_rx_push = 0;
    endtask

    task automatic tx_push_n(int n, int base);
        for (int i = 0; i < n; i++) begin
            host_wr = 1; host_wdata = 8'(base + i);
            tick();
        end
        host_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R3 reset state
        chk("R3 rx_count", rx_count, 0);
        chk("R3 tx_count", tx_count, 0);
        chk("R3 rx_irq", rx_irq, 0);
        chk("R3 tx_irq", tx_irq, 1);
        chk("R3 overrun", rx_overrun, 0);

        // threshold table walk (R3 R4 R5 R6 R7)
        foreach (VECS[k]) begin
            int cap;
            flush_both();
            write_cfg(VECS[k].en, VECS[k].rsel, VECS[k].tsel, VECS[k].rfine, VECS[k].tfine);
            flush_both();
            cap = VECS[k].en ? 64 : 1;
            rx_push_n(int'(VECS[k].rthr) - 1, 0);
            chk($sformatf("R7 rx below vec%0d", k), rx_irq, 0);
            rx_push_n(1, 0);
            chk($sformatf("R7 rx at vec%0d", k), rx_irq, 1);
            tx_push_n(cap - int'(VECS[k].tthr), 0);
            chk($sformatf("R7 tx at vec%0d", k), tx_irq, 1);
            tx_push_n(1, 0);
            chk($sformatf("R7 tx below vec%0d", k), tx_irq, 0);
        end

        // R2 ordering and error tags
        write_cfg(1, 0, 0, 0, 0);
        flush_both();
        ser_rx_push = 1; ser_rx_data = 8'hA5; ser_rx_err = 3'd1; tick();
        ser_rx_data = 8'h3C; ser_rx_err = 3'd6; tick();
        ser_rx_data = 8'h7E; ser_rx_err = 3'd0; tick();
        ser_rx_push = 0;
        chk("R2 count", rx_count, 3);
        chk("R2 data0", host_rdata, 8'hA5);
        chk("R2 err0", host_rerr, 1);
        host_rd = 1; tick(); host_rd = 0;
        chk("R2 data1", host_rdata, 8'h3C);
        chk("R2 err1", host_rerr, 6);
        host_rd = 1; tick(); host_rd = 0;
        chk("R2 data2", host_rdata, 8'h7E);

        // R9 overrun
        flush_both();
        rx_push_n(64, 0);
        chk("R9 full count", rx_count, 64);
        chk("R9 no overrun yet", rx_overrun, 0);
        rx_push_n(1, 8'h90);
        chk("R9 count held", rx_count, 64);
        chk("R9 overrun set", rx_overrun, 1);
        chk("R9 head kept", host_rdata, 0);
        tick();
        chk("R9 sticky", rx_overrun, 1);

        // R11 push and pop together on full queue
        ser_rx_push = 1; ser_rx_data = 8'hEE; host_rd = 1; tick();
        ser_rx_push = 0; host_rd = 0;
        chk("R11 full push+pop count", rx_count, 64);
        chk("R11 head advanced", host_rdata, 1);

        // R8 flush leaves the other queue and thresholds
        tx_push_n(5, 8'h40);
        rx_flush = 1; tick(); rx_flush = 0;
        chk("R8 rx emptied", rx_count, 0);
        chk("R8 overrun cleared", rx_overrun, 0);
        chk("R8 tx untouched", tx_count, 5);
        rx_push_n(8, 0);
        chk("R8 threshold kept", rx_irq, 1);
        rx_flush = 1; ser_rx_push = 1; tick(); rx_flush = 0; ser_rx_push = 0;
        chk("R8 flush beats push", rx_count, 0);

        // R11 pop on empty
        host_rd = 1; tick(); host_rd = 0;
        chk("R11 empty pop", rx_count, 0);

        // R1 transmit full write discarded
        tx_flush = 1; tick(); tx_flush = 0;
        tx_push_n(64, 8'h10);
        chk("R1 tx full", tx_count, 64);
        tx_push_n(1, 8'hFF);
        chk("R1 tx dropped", tx_count, 64);
        chk("R1 tx head", ser_tx_data, 8'h10);
        ser_tx_pop = 1; tick(); ser_tx_pop = 0;
        chk("R1 tx order", ser_tx_data, 8'h11);

        // R10 enable change empties both
        rx_push_n(3, 0);
        write_cfg(0, 0, 0, 0, 0);
        chk("R10 rx emptied", rx_count, 0);
        chk("R10 tx emptied", tx_count, 0);

        // R3 single-character mode overrun
        rx_push_n(2, 8'h20);
        chk("R3 single count", rx_count, 1);
        chk("R3 single overrun R9", rx_overrun, 1);
        chk("R3 single data", host_rdata, 8'h20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule